// File: doc/BRIEF.md
# Four-format host bus slave with buffer pointer

This block is the device side of an 8-bit asynchronous host bus. Two static strap inputs choose one of four bus formats: separate active-low read and write strobes, or a data strobe paired with a read/not-write line, each with either a dedicated 8-bit address bus or an address carried on the data bus ahead of the data phase and caught by a latch strobe. All bus control and data pins are brought into the core clock domain through a two-stage synchroniser, and a small state machine turns each completed access into a one-cycle register read or write strobe for the rest of the device.

The block owns a 16-bit buffer pointer made of two byte registers, and two byte-wide data ports that reach a transmit buffer and a receive buffer at the location held by that pointer. Both buffers are modelled inside the block as plain synchronous memories. Read data returns on a split pad interface (`ad_out` and an enable `ad_oe`), so the pad ring outside the block builds the shared bidirectional bus.

The access state machine has three states. `ST_IDLE` waits for an access; it moves to `ST_READ` when chip select and the read condition are both seen (capturing the address and pulsing `reg_rd`), or to `ST_WRITE` when chip select and the write condition are seen (capturing the address). `ST_READ` returns to `ST_IDLE` when the read condition or chip select drops. `ST_WRITE` samples the data bus every cycle it stays, and returns to `ST_IDLE` when the write condition or chip select drops, pulsing `reg_wr` with the last sampled data.

Top module: `hbus_host_if`

## Requirements
- R1: After reset both pointer bytes read as 0x00, `ad_oe` is low and no register strobe has been issued.
- R2: With `strap_moto` low, a low `rd_ds_n` with `cs_n` low is a read and a low `wr_rw` with `cs_n` low is a write.
- R3: With `strap_moto` high, a low `rd_ds_n` with `cs_n` low is a read when `wr_rw` is 1 and a write when `wr_rw` is 0.
- R4: With `strap_mux` high, the address is taken from `ad_in` while `ale` is high and the value present when `ale` falls is used; `ad_in` during the data phase does not change the address.
- R5: With `strap_mux` low, the address is taken from `addr_in` when the access begins; later changes of `addr_in` during the same access have no effect.
- R6: While `cs_n` is high, strobe activity causes no register strobe, no register change and no bus drive.
- R7: Register 0x08 holds pointer bits 15:8 and register 0x09 holds pointer bits 7:0; both are readable and writable.
- R8: Register 0x04 reads and writes the 2048-byte transmit buffer at pointer bits 10:0; higher pointer bits are ignored for this buffer.
- R9: Register 0x02 reads and writes the 4096-byte receive buffer at pointer bits 11:0; it is storage separate from the transmit buffer at the same pointer value.
- R10: Each write access yields exactly one one-cycle `reg_wr` pulse after the write condition ends, carrying the access address and data; each read access yields exactly one one-cycle `reg_rd` pulse; the two are never high together.
- R11: Any address other than 0x02, 0x04, 0x08 and 0x09 reads as 0x00, and writes to it change no register.
- R12: `ad_oe` is high only while `cs_n` is low and the read condition of the selected format holds on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_moto | input | 1 | Format strap: 1 = data strobe with read/not-write, 0 = separate read and write strobes |
| strap_mux | input | 1 | Format strap: 1 = address carried on the data bus, 0 = separate address bus |
| cs_n | input | 1 | Active-low chip select |
| rd_ds_n | input | 1 | Read strobe, or data strobe in the paired format, active low |
| wr_rw | input | 1 | Write strobe (active low), or read/not-write in the paired format |
| ale | input | 1 | Address latch strobe, active high, used when `strap_mux` is 1 |
| addr_in | input | 8 | Separate address bus |
| ad_in | input | 8 | Data bus from the pad (address and data when multiplexed) |
| ad_out | output | 8 | Read data toward the pad |
| ad_oe | output | 1 | Pad output enable for `ad_out` |
| reg_rd | output | 1 | One-cycle register read strobe |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_addr | output | 8 | Register address of the current access |
| reg_wdata | output | 8 | Write data accompanying `reg_wr` |

## Verification
The bench runs the same pointer, transmit and receive traffic in all four strap combinations, so a design that swapped strobe roles or ignored the read/not-write line would return wrong data or miss writes in one format only. In the multiplexed formats it puts a different value on the data bus during a read, and in the separate-address formats it moves `addr_in` to a reserved address in the middle of each access; a design that kept tracking the bus would read zero or hit the wrong register. Pointer values above the transmit buffer size show whether the two buffers alias or truncate the pointer wrongly, and counting strobes per access exposes a design that fires on both edges or on repeated cycles. Accesses with chip select high and writes to reserved addresses must leave the pointer untouched.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE
    } hbus_state_e;

    typedef enum logic [2:0] {
        SEL_ZERO,
        SEL_PTR_HI,
        SEL_PTR_LO,
        SEL_TXBUF,
        SEL_RXBUF
    } hbus_rsel_e;

    localparam logic [7:0] ADDR_RXBUF  = 8'h02;
    localparam logic [7:0] ADDR_TXBUF  = 8'h04;
    localparam logic [7:0] ADDR_PTR_HI = 8'h08;
    localparam logic [7:0] ADDR_PTR_LO = 8'h09;

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= RST_VAL;
            end
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/hbus_buf.sv
module hbus_buf #(
    parameter int AW = 11,
    parameter int DW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        if (re) begin
            rdata <= mem[addr];
        end
    end

endmodule

// File: rtl/hbus_strobe_fsm.sv
module hbus_strobe_fsm
    import hbus_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strap_moto,
    input  logic          strap_mux,
    input  logic          cs_n_s,
    input  logic          sa_n_s,
    input  logic          sb_s,
    input  logic          ale_s,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] ad_s,
    output logic          reg_rd,
    output logic          reg_wr,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata
);

    hbus_state_e   state_q, state_d;
    logic          rd_act, wr_act;
    logic [AW-1:0] ale_addr_q;
    logic [AW-1:0] cur_addr;

    // Access conditions seen in the core clock domain.
    always_comb begin
        if (strap_moto) begin
            rd_act = !cs_n_s && !sa_n_s &&  sb_s;
            wr_act = !cs_n_s && !sa_n_s && !sb_s;
        end else begin
            rd_act = !cs_n_s && !sa_n_s;
            wr_act = !cs_n_s && !sb_s && sa_n_s;
        end
    end

    // Multiplexed address holding register: follows the bus while the latch strobe is high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ale_addr_q <= '0;
        end else if (ale_s) begin
            ale_addr_q <= ad_s[AW-1:0];
        end
    end

    assign cur_addr = strap_mux ? ale_addr_q : addr_s;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_act) begin
                    state_d = ST_READ;
                end else if (wr_act) begin
                    state_d = ST_WRITE;
                end
            end
            ST_READ: begin
                if (!rd_act) begin
                    state_d = ST_IDLE;
                end
            end
            ST_WRITE: begin
                if (!wr_act) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Registered outputs toward the register file.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rd    <= 1'b0;
            reg_wr    <= 1'b0;
            reg_addr  <= '0;
            reg_wdata <= '0;
        end else begin
            reg_rd <= (state_q == ST_IDLE) && rd_act;
            reg_wr <= (state_q == ST_WRITE) && !wr_act;
            if ((state_q == ST_IDLE) && (rd_act || wr_act)) begin
                reg_addr <= cur_addr;
            end
            if ((state_q == ST_WRITE) && wr_act) begin
                reg_wdata <= ad_s;
            end
        end
    end

endmodule

// File: rtl/hbus_regfile.sv
module hbus_regfile
    import hbus_pkg::*;
#(
    parameter int TX_AW = 11,
    parameter int RX_AW = 12,
    parameter int PW    = 16,
    localparam int DW   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_rd,
    input  logic          reg_wr,
    input  logic [7:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] rdata,
    output logic [PW-1:0] ptr
);

    logic [PW-1:0] ptr_q;
    hbus_rsel_e    sel_q;
    logic [DW-1:0] tx_rdata, rx_rdata;
    logic          tx_we, rx_we, tx_re, rx_re;

    assign tx_we = reg_wr && (reg_addr == ADDR_TXBUF);
    assign rx_we = reg_wr && (reg_addr == ADDR_RXBUF);
    assign tx_re = reg_rd && (reg_addr == ADDR_TXBUF);
    assign rx_re = reg_rd && (reg_addr == ADDR_RXBUF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_PTR_HI) begin
                ptr_q[PW-1:DW] <= reg_wdata;
            end else if (reg_addr == ADDR_PTR_LO) begin
                ptr_q[DW-1:0] <= reg_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= SEL_ZERO;
        end else if (reg_rd) begin
            unique case (reg_addr)
                ADDR_PTR_HI: sel_q <= SEL_PTR_HI;
                ADDR_PTR_LO: sel_q <= SEL_PTR_LO;
                ADDR_TXBUF:  sel_q <= SEL_TXBUF;
                ADDR_RXBUF:  sel_q <= SEL_RXBUF;
                default:     sel_q <= SEL_ZERO;
            endcase
        end
    end

    hbus_buf #(.AW(TX_AW), .DW(DW)) u_txbuf (
        .clk   (clk),
        .we    (tx_we),
        .re    (tx_re),
        .addr  (ptr_q[TX_AW-1:0]),
        .wdata (reg_wdata),
        .rdata (tx_rdata)
    );

    hbus_buf #(.AW(RX_AW), .DW(DW)) u_rxbuf (
        .clk   (clk),
        .we    (rx_we),
        .re    (rx_re),
        .addr  (ptr_q[RX_AW-1:0]),
        .wdata (reg_wdata),
        .rdata (rx_rdata)
    );

    always_comb begin
        unique case (sel_q)
            SEL_PTR_HI: rdata = ptr_q[PW-1:DW];
            SEL_PTR_LO: rdata = ptr_q[DW-1:0];
            SEL_TXBUF:  rdata = tx_rdata;
            SEL_RXBUF:  rdata = rx_rdata;
            default:    rdata = '0;
        endcase
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/hbus_host_if.sv
module hbus_host_if #(
    parameter int TX_AW      = 11,
    parameter int RX_AW      = 12,
    parameter int SYNC_DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strap_moto,
    input  logic       strap_mux,
    input  logic       cs_n,
    input  logic       rd_ds_n,
    input  logic       wr_rw,
    input  logic       ale,
    input  logic [7:0] addr_in,
    input  logic [7:0] ad_in,
    output logic [7:0] ad_out,
    output logic       ad_oe,
    output logic       reg_rd,
    output logic       reg_wr,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata
);

    localparam int PW = 16;

    logic       cs_n_s, sa_n_s, sb_s, ale_s;
    logic [7:0] addr_s, ad_s;
    logic [PW-1:0] ptr_q;

    hbus_sync #(.W(4), .STAGES(SYNC_DEPTH), .RST_VAL(4'b1110)) u_ctl_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, rd_ds_n, wr_rw, ale}),
        .q     ({cs_n_s, sa_n_s, sb_s, ale_s})
    );

    hbus_sync #(.W(16), .STAGES(SYNC_DEPTH), .RST_VAL(16'h0000)) u_bus_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({addr_in, ad_in}),
        .q     ({addr_s, ad_s})
    );

    hbus_strobe_fsm #(.AW(8), .DW(8)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_moto (strap_moto),
        .strap_mux  (strap_mux),
        .cs_n_s     (cs_n_s),
        .sa_n_s     (sa_n_s),
        .sb_s       (sb_s),
        .ale_s      (ale_s),
        .addr_s     (addr_s),
        .ad_s       (ad_s),
        .reg_rd     (reg_rd),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata)
    );

    hbus_regfile #(.TX_AW(TX_AW), .RX_AW(RX_AW), .PW(PW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .rdata     (ad_out),
        .ptr       (ptr_q)
    );

    // Pad drive follows the raw pins so the bus is released as soon as the host lets go.
    assign ad_oe = !cs_n && !rd_ds_n && (strap_moto ? wr_rw : 1'b1);

endmodule

// File: rtl/hbus_host_if_chk.sv
module hbus_host_if_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_rd,
    input logic        reg_wr,
    input logic [7:0]  reg_addr,
    input logic [7:0]  reg_wdata,
    input logic [15:0] ptr
);

    logic reserved;
    assign reserved = !(reg_addr inside {8'h02, 8'h04, 8'h08, 8'h09});

    // R10
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    // R10
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);

    // R10
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr));

    // R7
    ptr_hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 8'h08) |=> (ptr[15:8] == $past(reg_wdata)));

    // R7
    ptr_lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 8'h09) |=> (ptr[7:0] == $past(reg_wdata)));

    // R11
    reserved_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reserved) |=> $stable(ptr));

    // R6
    idle_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(ptr));

endmodule

bind hbus_host_if hbus_host_if_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .ptr       (ptr_q)
);

// File: tb/hbus_host_if_test.sv
module hbus_host_if_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_moto = 1'b0;
    logic       strap_mux = 1'b0;
    logic       cs_n = 1'b1;
    logic       rd_ds_n = 1'b1;
    logic       wr_rw = 1'b1;
    logic       ale = 1'b0;
    logic [7:0] addr_in = 8'h00;
    logic [7:0] ad_in = 8'h00;
    logic [7:0] ad_out;
    logic       ad_oe;
    logic       reg_rd, reg_wr;
    logic [7:0] reg_addr, reg_wdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    hbus_host_if uut (
        .clk(clk), .rst_n(rst_n), .strap_moto(strap_moto), .strap_mux(strap_mux),
        .cs_n(cs_n), .rd_ds_n(rd_ds_n), .wr_rw(wr_rw), .ale(ale),
        .addr_in(addr_in), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
    );

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // Reference model, built from the requirements.
    logic [15:0] ptr_m = 16'h0000;
    logic [7:0]  tx_m [2048];
    logic [7:0]  rx_m [4096];

    // Scoreboard queues.
    logic [7:0] exp_q [$];
    logic [7:0] act_q [$];
    string      tag_q [$];

    int         wr_pulses = 0;
    int         rd_pulses = 0;
    logic [7:0] last_a = 8'h00;
    logic [7:0] last_d = 8'h00;

    always @(posedge clk) begin
        if (reg_wr) begin
            wr_pulses <= wr_pulses + 1;
            last_a    <= reg_addr;
            last_d    <= reg_wdata;
        end
        if (reg_rd) rd_pulses <= rd_pulses + 1;
    end

    // Monitor: pops observed read data and compares with the expected queue.
    always @(negedge clk) begin
        while (act_q.size() > 0) begin
            logic [7:0] a, e;
            string t;
            a = act_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            tests++;
            if (a !== e) begin
                fails++;
                $display("FAIL %s read data act=%02h exp=%02h", t, a, e);
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [7:0] a);
        case (a)
            8'h08:   return ptr_m[15:8];
            8'h09:   return ptr_m[7:0];
            8'h04:   return tx_m[ptr_m[10:0]];
            8'h02:   return rx_m[ptr_m[11:0]];
            default: return 8'h00;
        endcase
    endfunction

    function automatic string fmt_tag();
        return {strap_moto ? "R3" : "R2", "/", strap_mux ? "R4" : "R5"};
    endfunction

    task automatic access(input logic is_rd, input logic [7:0] a, input logic [7:0] d,
                          input logic cs_on, output logic [7:0] q, output logic oe_seen);
        q = 8'h00;
        oe_seen = 1'b0;
        @(negedge clk);
        if (strap_mux) begin
            ad_in = a;
            ale = 1'b1;
            repeat (4) @(negedge clk);
            ale = 1'b0;
            repeat (2) @(negedge clk);
        end else begin
            addr_in = a;
        end
        cs_n = !cs_on;
        if (strap_moto) wr_rw = is_rd;
        repeat (2) @(negedge clk);
        ad_in = is_rd ? 8'hEE : d;
        if (strap_moto || is_rd) rd_ds_n = 1'b0;
        else wr_rw = 1'b0;
        repeat (4) @(negedge clk);
        if (!strap_mux) addr_in = 8'h30;
        repeat (4) @(negedge clk);
        q = ad_out;
        oe_seen = ad_oe;
        rd_ds_n = 1'b1;
        if (!strap_moto) wr_rw = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        wr_rw = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d, input string tag);
        int c0;
        logic [7:0] q;
        logic o;
        c0 = wr_pulses;
        access(1'b0, a, d, 1'b1, q, o);
        check({"R10 pulse count ", tag}, wr_pulses - c0, 1);
        check({"R10 addr/data ", tag}, {last_a, last_d}, {a, d});
        case (a)
            8'h08: ptr_m[15:8] = d;
            8'h09: ptr_m[7:0]  = d;
            8'h04: tx_m[ptr_m[10:0]] = d;
            8'h02: rx_m[ptr_m[11:0]] = d;
            default: ;
        endcase
    endtask

    task automatic bus_read(input logic [7:0] a, input string tag);
        int c0;
        logic [7:0] q;
        logic o;
        c0 = rd_pulses;
        access(1'b1, a, 8'h00, 1'b1, q, o);
        check({"R12 oe during read ", tag}, int'(o), 1);
        check({"R10 read pulse ", tag}, rd_pulses - c0, 1);
        exp_q.push_back(model_read(a));
        tag_q.push_back(tag);
        act_q.push_back(q);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] q;
        logic o;
        int c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: reset state
        check("R1 oe after reset", int'(ad_oe), 0);
        check("R1 no strobes after reset", wr_pulses + rd_pulses, 0);
        bus_read(8'h08, "R1 ptr hi");
        bus_read(8'h09, "R1 ptr lo");

        // R2..R5, R7..R9 across all four formats
        for (int f = 0; f < 4; f++) begin
            strap_moto = f[1];
            strap_mux  = f[0];
            repeat (4) @(negedge clk);
            bus_write(8'h08, 8'(f), {fmt_tag(), " R7"});
            bus_write(8'h09, 8'(8'h10 + 3 * f), {fmt_tag(), " R7"});
            bus_read(8'h08, {fmt_tag(), " R7 hi"});
            bus_read(8'h09, {fmt_tag(), " R7 lo"});
            bus_write(8'h04, 8'(8'hA0 + f), {fmt_tag(), " R8"});
            bus_write(8'h02, 8'(8'h50 + f), {fmt_tag(), " R9"});
            bus_read(8'h04, {fmt_tag(), " R8 tx"});
            bus_read(8'h02, {fmt_tag(), " R9 rx"});
        end

        strap_moto = 1'b0;
        strap_mux  = 1'b0;
        repeat (4) @(negedge clk);

        // R11: reserved address
        bus_write(8'h30, 8'hFF, "R11 reserved write");
        bus_read(8'h30, "R11 reserved read");
        bus_read(8'h09, "R11 ptr unchanged");

        // R6: chip select high, write and read attempts
        c0 = wr_pulses;
        access(1'b0, 8'h09, 8'h77, 1'b0, q, o);
        check("R6 no write pulse", wr_pulses - c0, 0);
        c0 = rd_pulses;
        access(1'b1, 8'h09, 8'h00, 1'b0, q, o);
        check("R6 no read pulse", rd_pulses - c0, 0);
        check("R6 R12 no drive with cs high", int'(o), 0);
        bus_read(8'h09, "R6 ptr lo unchanged");

        // R8/R9: pointer bits above each buffer width
        bus_write(8'h08, 8'h08, "R8 ptr hi");
        bus_write(8'h09, 8'h05, "R8 ptr lo");
        bus_write(8'h04, 8'h3C, "R8 tx high ptr");
        bus_write(8'h02, 8'h11, "R9 rx high ptr");
        bus_write(8'h08, 8'h00, "R8 ptr hi low");
        bus_write(8'h02, 8'h22, "R9 rx low ptr");
        bus_read(8'h04, "R8 tx alias");
        bus_read(8'h02, "R9 rx low");
        bus_write(8'h08, 8'h08, "R9 ptr hi back");
        bus_read(8'h02, "R9 rx high distinct");
        bus_read(8'h04, "R8 tx alias again");

        // R3/R4: multiplexed paired-strobe format after the aliasing traffic
        strap_moto = 1'b1;
        strap_mux  = 1'b1;
        repeat (4) @(negedge clk);
        bus_read(8'h08, "R3/R4 final ptr hi");
        bus_read(8'h04, "R3/R4 final tx");

        repeat (10) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule